// File: doc/BRIEF.md
# Slow-Clock System Timer

This block is a CPU-facing system timer whose time base is a 32768 Hz slow clock that runs asynchronously to the bus clock. Each rising edge of the slow clock is one tick. A programmable divider turns ticks into increments of a free-running real-time counter. An absolute-value alarm compares against that counter. An independent periodic interval timer fires every programmed number of ticks and keeps running.

Four event flags gather in a sticky status register. Reading that register clears it. Separate set and clear registers program a per-flag interrupt mask, and a single level interrupt is raised while any unmasked flag is pending. Software reads and writes the registers over a simple single-cycle bus. The slow clock is brought into the bus domain through a synchronizer, so every counter read is coherent and monotonic.

Register word index (byte address bits [4:2]): 0 divider, 1 periodic length, 2 alarm, 3 status, 4 mask-set, 5 mask-clear, 6 mask readback, 7 counter. Flag bit positions: 0 periodic, 1 watchdog (never set here), 2 counter increment, 3 alarm.

Top module: `slowclk_sys_timer`

## Requirements
- R1: After reset the divider reads 0x8000, the periodic length reads 0, the alarm reads all ones over the counter width, and status, mask, counter and `irq` are all 0.
- R2: The counter advances once every N ticks, where N is the divider value and a divider of 0 means 65536. Writing the divider (index 0) restarts the division and clears the counter to 0.
- R3: The counter is CNT_W bits wide (20 by default). It only ever steps by +1 modulo 2^CNT_W, except that it is cleared by a divider write.
- R4: Status bit 2 sets on every counter advance.
- R5: Status bit 3 sets when the counter steps onto the alarm value (index 2). An alarm written equal to the counter's current value does not match until the counter has wrapped.
- R6: Status bit 0 sets every P ticks and the timer keeps running, where P is the periodic length (index 1) and 0 means 65536. Writing the length restarts the interval.
- R7: A read of status (index 3) returns the pending flags and clears them. A flag that sets in the same cycle as the read is kept. Bit 1 always reads 0.
- R8: Writing index 4 sets the mask bits where the data has a 1, and writing index 5 clears them. Zero bits leave the mask unchanged. Index 6 returns the mask, and indices 4 and 5 read 0.
- R9: `irq` is high exactly while some status bit and its mask bit are both 1.
- R10: A slow-clock rising edge takes effect on the counters at the third bus-clock edge after it. Register reads therefore never return a torn value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, bus domain |
| slow_clk | input | 1 | 32768 Hz time base, asynchronous |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions and the reference model take for granted that the bus clock is much faster than the slow clock. Each slow-clock high and low phase must last at least two bus cycles, so that no tick is merged or missed by the synchronizer. The model also assumes one access per strobe at an aligned address. The bench keeps to this by giving the slow clock two bus cycles high and two low, and by generating only aligned single-cycle accesses. It also shrinks the counter width so that a full wrap, and with it the delayed alarm, fits in the run.

// File: rtl/slowclk_sys_timer.sv
`timescale 1ns/1ps
module slowclk_sys_timer #(
  parameter int CNT_W     = 20,
  parameter int DIV_W     = 16,
  parameter int PRESC_RST = 32768
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slow_clk,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  localparam logic [DIV_W:0] DIV_FULL = {1'b1, {DIV_W{1'b0}}};

  function automatic logic [DIV_W:0] span(input logic [DIV_W-1:0] v);
    return (v == '0) ? DIV_FULL : {1'b0, v};
  endfunction

  logic [2:0]       sync;
  logic [DIV_W-1:0] presc, period;
  logic [DIV_W:0]   pdiv, pitc;
  logic [CNT_W-1:0] cnt, alarm;
  logic [3:0]       status, mask;

  wire [2:0] idx       = bus_addr[4:2];
  wire       wr        = bus_sel & bus_wr;
  wire       rd        = bus_sel & ~bus_wr;
  wire       wr_presc  = wr && idx == 3'd0;
  wire       wr_period = wr && idx == 3'd1;
  wire       wr_alarm  = wr && idx == 3'd2;
  wire       rd_status = rd && idx == 3'd3;
  wire       wr_en     = wr && idx == 3'd4;
  wire       wr_dis    = wr && idx == 3'd5;

  logic unused_bits;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:CNT_W]};

  // R10: slow clock resampled, one tick per rising edge
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= '0;
    else        sync <= {sync[1:0], slow_clk};

  wire tick    = sync[1] & ~sync[2];
  wire step    = tick & ~wr_presc & (pdiv + 1'b1 == span(presc));
  wire pit_due = tick & ~wr_period & (pitc + 1'b1 == span(period));
  wire [CNT_W-1:0] cnt_nxt = cnt + 1'b1;
  wire [3:0] flags_set = {step & (cnt_nxt == alarm), step, 1'b0, pit_due};

  // R2 R3: divider and counter
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      presc <= DIV_W'(PRESC_RST);
      pdiv  <= '0;
      cnt   <= '0;
    end else if (wr_presc) begin
      presc <= bus_wdata[DIV_W-1:0];
      pdiv  <= '0;
      cnt   <= '0;
    end else if (tick) begin
      pdiv <= step ? '0 : pdiv + 1'b1;
      if (step) cnt <= cnt_nxt;
    end

  // R6: periodic interval timer
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      period <= '0;
      pitc   <= '0;
    end else if (wr_period) begin
      period <= bus_wdata[DIV_W-1:0];
      pitc   <= '0;
    end else if (tick) begin
      pitc <= pit_due ? '0 : pitc + 1'b1;
    end

  // R5 R7 R8: alarm, sticky status, mask
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      alarm  <= '1;
      status <= '0;
      mask   <= '0;
    end else begin
      if (wr_alarm) alarm <= bus_wdata[CNT_W-1:0];
      status <= (rd_status ? 4'b0 : status) | flags_set;
      if (wr_en)  mask <= mask | bus_wdata[3:0];
      if (wr_dis) mask <= mask & ~bus_wdata[3:0];
    end

  always_comb begin
    bus_rdata = '0;
    if (rd)
      case (idx)
        3'd0:    bus_rdata[DIV_W-1:0] = presc;
        3'd1:    bus_rdata[DIV_W-1:0] = period;
        3'd2:    bus_rdata[CNT_W-1:0] = alarm;
        3'd3:    bus_rdata[3:0]       = status;
        3'd6:    bus_rdata[3:0]       = mask;
        3'd7:    bus_rdata[CNT_W-1:0] = cnt;
        default: bus_rdata            = '0;
      endcase
  end

  // R9
  assign irq = |(status & mask);

  assert_cnt_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 1'b1) || $past(wr_presc));

  assert_inc_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) && !$past(wr_presc) |-> status[2]);

  assert_alarm_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) && !$past(wr_presc) && (alarm == $past(alarm)) && (cnt == alarm)
      |-> status[3]);

  assert_flags_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_status |=> ((status & $past(status)) == $past(status)));

  assert_mask_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((mask & $past(bus_wdata[3:0])) == $past(bus_wdata[3:0])));

  assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> irq || $past(rd_status) || $past(wr_dis));
endmodule

// File: tb/slowclk_sys_timer_test.sv
`timescale 1ns/1ps
module slowclk_sys_timer_test;
  localparam int CW = 12;

  logic        clk = 0, rst_n = 0, slow_clk = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  wire  [31:0] bus_rdata;
  wire         irq;
  int vectors = 0, miscompares = 0;
  bit done = 0;

  always #5 clk = ~clk;

  slowclk_sys_timer #(.CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  initial forever begin
    repeat (2) @(negedge clk);
    slow_clk = ~slow_clk;
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  // Behavioural reference: counts ticks since each restart
  int m_presc, m_per, m_alarm, m_stat, m_mask, m_cnt, m_dtk, m_ptk;
  bit seen [3];
  always @(posedge clk) begin
    int divn, pern, newf;
    bit tk;
    if (!rst_n) begin
      m_presc = 32768; m_per = 0; m_alarm = (1 << CW) - 1;
      m_stat = 0; m_mask = 0; m_cnt = 0; m_dtk = 0; m_ptk = 0;
      seen[0] = 0; seen[1] = 0; seen[2] = 0;
    end else begin
      tk = seen[1] && !seen[2];
      seen[2] = seen[1]; seen[1] = seen[0]; seen[0] = slow_clk;
      divn = (m_presc == 0) ? 65536 : m_presc;
      pern = (m_per == 0) ? 65536 : m_per;
      newf = 0;
      if (bus_sel && bus_wr && bus_addr[4:2] == 0) begin
        m_presc = bus_wdata & 'hFFFF; m_dtk = 0; m_cnt = 0;
      end else if (tk) begin
        m_dtk++;
        if (m_dtk % divn == 0) begin
          m_cnt = (m_cnt + 1) % (1 << CW);
          newf |= 4;
          if (m_cnt == m_alarm) newf |= 8;
        end
      end
      if (bus_sel && bus_wr && bus_addr[4:2] == 1) begin
        m_per = bus_wdata & 'hFFFF; m_ptk = 0;
      end else if (tk) begin
        m_ptk++;
        if (m_ptk % pern == 0) newf |= 1;
      end
      if (bus_sel && !bus_wr && bus_addr[4:2] == 3) m_stat = 0;
      m_stat |= newf;
      if (bus_sel && bus_wr && bus_addr[4:2] == 2) m_alarm = bus_wdata & ((1 << CW) - 1);
      if (bus_sel && bus_wr && bus_addr[4:2] == 4) m_mask |= bus_wdata & 'hF;
      if (bus_sel && bus_wr && bus_addr[4:2] == 5) m_mask &= ~bus_wdata & 'hF;
    end
  end

  function automatic logic [31:0] exp_rd(input logic [2:0] i);
    case (i)
      3'd0: return m_presc;
      3'd1: return m_per;
      3'd2: return m_alarm;
      3'd3: return m_stat;
      3'd6: return m_mask;
      3'd7: return m_cnt;
      default: return 0;
    endcase
  endfunction

  function automatic string rtag(input logic [2:0] i);
    case (i)
      3'd0: return "R2 divider";
      3'd1: return "R6 period";
      3'd2: return "R5 alarm";
      3'd3: return "R4 R5 R6 R7 status";
      3'd7: return "R2 R3 R10 counter";
      default: return "R8 mask";
    endcase
  endfunction

  always @(posedge clk) begin
    #8;
    if (rst_n && !done) begin
      check("R9 irq", {31'b0, irq}, {31'b0, (m_stat & m_mask) != 0});
      if (bus_sel && !bus_wr) check(rtag(bus_addr[4:2]), bus_rdata, exp_rd(bus_addr[4:2]));
    end
  end

  task automatic wr(input logic [2:0] i, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = {i, 2'b00}; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] i, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = {i, 2'b00};
    #3 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vectors++; miscompares++;
    $display("FAIL watchdog all requirements actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v, prev;
    repeat (4) @(negedge clk);
    rst_n = 1;
    check("R1 irq", {31'b0, irq}, 0);
    rd(0, v); check("R1 divider", v, 32'h8000);
    rd(1, v); check("R1 period", v, 0);
    rd(2, v); check("R1 alarm", v, (1 << CW) - 1);
    rd(3, v); check("R1 status", v, 0);
    rd(6, v); check("R1 mask", v, 0);
    repeat (40) @(negedge clk);
    rd(7, v); check("R1 R2 counter held by large divider", v, 0);

    wr(4, 9);  rd(6, v); check("R8 mask set", v, 9);
    wr(5, 1);  rd(6, v); check("R8 mask clear", v, 8);
    wr(4, 0);  rd(6, v); check("R8 zero set no effect", v, 8);
    wr(5, 0);  rd(6, v); check("R8 zero clear no effect", v, 8);
    rd(4, v);  check("R8 set reg reads 0", v, 0);
    wr(4, 'hF);

    wr(0, 1); wr(1, 5);
    rd(7, prev);
    for (int k = 0; k < 120; k++) begin
      repeat ($urandom % 5) @(negedge clk);
      rd(((k % 3) == 0) ? 3'd3 : 3'd7, v);
    end
    rd(7, v); check("R3 counter advanced", {31'b0, v != prev}, 1);

    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = {3'd3, 2'b00};
    repeat (24) @(negedge clk);
    bus_sel = 0;

    wr(0, 3); wr(1, 7);
    rd(7, v); wr(2, (v + 5) % (1 << CW));
    for (int k = 0; k < 60; k++) begin
      repeat (6) @(negedge clk);
      rd(3, v);
    end
    wr(5, 'hF); wr(4, 8);
    repeat (100) @(negedge clk);

    wr(0, 256); wr(1, 0); wr(2, 0); rd(3, v);
    repeat (3500) @(negedge clk);
    rd(3, v);
    check("R5 alarm at current value no match", v[3], 0);
    check("R4 increments flagged", v[2], 1);
    check("R6 period zero is 65536", v[0], 0);

    wr(0, 1); rd(3, v);
    repeat (4096 * 4 + 60) @(negedge clk);
    check("R9 irq from alarm after wrap", {31'b0, irq}, 1);
    rd(7, v); check("R3 counter wrapped", {31'b0, v < 20}, 1);
    rd(3, v); check("R5 alarm after wrap", v[3], 1);
    check("R7 watchdog bit", v[1], 0);
    repeat (3) @(negedge clk);
    check("R7 R9 irq after status read", {31'b0, irq}, 0);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule